// File: doc/BRIEF.md
# Serial Receiver with Line-Break Detection

This block receives asynchronous serial frames from a single input line that it samples at sixteen times the bit rate. The oversampling rate comes from a one-cycle clock-enable pulse, `tick`, that a divider elsewhere produces. Each frame has a low start bit, `DATA_W` data bits sent least significant bit first, an optional parity bit (even or odd), and one stop bit. A received byte is presented for one clock cycle, together with its parity-error and framing-error flags. Those two flags then keep their value until the next frame is delivered.

A line break is a frame in which every sampled level is low. The block handles a break as an event of its own, separate from a framing error. It sets a sticky break-status flag when the low stop bit of an all-zero frame is sampled. It then waits in a break state until the line has been high for two oversampling ticks in a row. At that point it sets the same flag again, so that software which cleared the flag in between sees a second event for the end of the break. A one-cycle `clr_status` pulse clears the break-status flag.

Top module: `uart_rx_brk`

## Requirements
- R1: While `rst_n` is low, and after its release until the first frame ends, `rx_valid`, `rx_data`, `par_err`, `frm_err` and `brk_flag` are all 0.
- R2: The line passes through a two-flop synchronizer. A low level seen on a tick starts a frame, and that tick is tick 0 of the start bit. Each bit then lasts 16 ticks, and its value is the majority of its samples at ticks 7, 8 and 9. Data bits arrive least significant bit first. On the clock edge of the stop bit's tick 9, `rx_valid` rises for exactly one cycle and `rx_data` takes the byte.
- R3: `par_mode` selects the parity mode: 2'b00 or 2'b11 means no parity bit, 2'b01 means even parity (the count of ones over data plus parity bit is even), and 2'b10 means odd parity. `par_err` is updated with each `rx_valid` pulse. It is 1 on a mismatch and always 0 when parity is off.
- R4: A frame whose stop bit samples low but whose data (or enabled parity bit) is not all zero raises `rx_valid` with `frm_err` = 1, and it leaves `brk_flag` unchanged.
- R5: A frame whose data bits, enabled parity bit and stop bit all sample low is a break. It sets `brk_flag` on the edge of the stop bit's tick 9. It produces no `rx_valid` and leaves `rx_data`, `par_err` and `frm_err` unchanged.
- R6: With parity off, the break test covers only the data bits and the stop bit. With parity on, a parity bit sampled high turns an all-zero, low-stop frame into a framing error (R4) and not a break.
- R7: After a break, the end of the break is detected on the second consecutive tick that sees the line high. This sets `brk_flag` again, and the receiver returns to idle, ready for a new start bit.
- R8: `brk_flag` stays set until a one-cycle `clr_status` pulse clears it. A break start or break end in the same cycle as `clr_status` wins, and the flag stays set.
- R9: While in the break state, a tick that sees the line low restarts the count of high ticks. No start bit is accepted and no frame is produced until the end of the break has been detected.
- R10: If the start bit's majority at ticks 7 to 9 is high, the low pulse is treated as a glitch. The receiver returns to idle with no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| par_mode | input | 2 | Parity mode: 00 or 11 none, 01 even, 10 odd |
| clr_status | input | 1 | One-cycle pulse that clears the break-status flag |
| rx_data | output | DATA_W | Last received data word |
| rx_valid | output | 1 | One-cycle strobe for a delivered frame |
| par_err | output | 1 | Parity error of the last delivered frame |
| frm_err | output | 1 | Framing error of the last delivered frame |
| brk_flag | output | 1 | Sticky break start/end status |

## Verification
The assertions take for granted that `clr_status` is a single-cycle pulse and that `par_mode` is held steady from a start bit to its stop bit. `tick` may be high on every cycle or on any sparser pattern. The stimulus changes `par_mode` only while the line idles high between frames, and it drives each level for a counted number of ticks. The tick spacing is varied between runs, including a tick on every cycle. The line levels, the parity modes and the clear pulses are all driven at the falling clock edge.

// File: rtl/uart_rx_brk_pkg.sv
package uart_rx_brk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BREAK
  } rx_state_t;

  localparam logic [1:0] PM_NONE = 2'b00;
  localparam logic [1:0] PM_EVEN = 2'b01;
  localparam logic [1:0] PM_ODD  = 2'b10;

  // majority of three samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic parity_on(input logic [1:0] mode);
    return (mode == PM_EVEN) || (mode == PM_ODD);
  endfunction

  // data_xor: XOR reduction of the data word
  function automatic logic parity_bad(input logic data_xor, input logic pbit,
                                      input logic [1:0] mode);
    logic odd_ones;
    odd_ones = data_xor ^ pbit;
    case (mode)
      PM_EVEN: return odd_ones;
      PM_ODD:  return ~odd_ones;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxb_bit_timer.sv
module rxb_bit_timer
  import uart_rx_brk_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic restart,   // start detected in idle
  input  logic active,    // inside a frame
  output logic bit_mid,   // decision tick of the current bit
  output logic bit_val,   // majority value, valid with bit_mid
  output logic bit_end    // last tick of the current bit
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] SMP_A = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] SMP_B = CW'(OVS/2);
  localparam logic [CW-1:0] SMP_C = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] LAST  = CW'(OVS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;
  logic [1:0]    smp;

  assign nxt = (cnt == LAST) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      smp <= '0;
    end else if (tick) begin
      if (restart) begin
        cnt <= '0;
      end else if (active) begin
        cnt <= nxt;
        if (nxt == SMP_A) smp[0] <= rx;
        if (nxt == SMP_B) smp[1] <= rx;
      end
    end
  end

  assign bit_mid = tick && active && (nxt == SMP_C);
  assign bit_end = tick && active && (cnt == LAST);
  assign bit_val = vote3(smp[0], smp[1], rx);
endmodule

// File: rtl/rxb_frame_fsm.sv
module rxb_frame_fsm
  import uart_rx_brk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int END_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic [1:0]        par_mode,
  input  logic              bit_mid,
  input  logic              bit_val,
  input  logic              bit_end,
  output logic              restart,
  output logic              active,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              perr_q,
  output logic              ferr_q,
  output logic              frame_done,
  output logic              brk_start,
  output logic              brk_end,
  output logic              in_break
);
  localparam int IW = $clog2(DATA_W + 1);
  localparam int HW = $clog2(END_TICKS + 1);
  localparam logic [IW-1:0] IDX_FULL = IW'(DATA_W);
  localparam logic [HW-1:0] HI_LAST  = HW'(END_TICKS - 1);

  rx_state_t         st;
  logic [DATA_W-1:0] shreg;
  logic [IW-1:0]     idx;
  logic              pbit;
  logic [HW-1:0]     hi_cnt;
  logic              par_en;
  logic              all_low;

  assign par_en   = parity_on(par_mode);
  assign restart  = tick && (st == ST_IDLE) && !rx;
  assign active   = (st == ST_START) || (st == ST_DATA) ||
                    (st == ST_PAR)   || (st == ST_STOP);
  assign in_break = (st == ST_BREAK);

  assign all_low    = (shreg == '0) && !(par_en && pbit) && !bit_val;
  assign brk_start  = (st == ST_STOP) && bit_mid && all_low;
  assign frame_done = (st == ST_STOP) && bit_mid && !all_low;
  assign brk_end    = in_break && tick && rx && (hi_cnt == HI_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      shreg   <= '0;
      idx     <= '0;
      pbit    <= 1'b0;
      hi_cnt  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (st)
        ST_IDLE: if (restart) st <= ST_START;
        ST_START: begin
          if (bit_mid && bit_val) st <= ST_IDLE;
          else if (bit_end) begin
            st  <= ST_DATA;
            idx <= '0;
          end
        end
        ST_DATA: begin
          if (bit_mid) begin
            shreg <= {bit_val, shreg[DATA_W-1:1]};
            idx   <= idx + 1'b1;
          end
          if (bit_end && idx == IDX_FULL) st <= par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: begin
          if (bit_mid) pbit <= bit_val;
          if (bit_end) st <= ST_STOP;
        end
        ST_STOP: begin
          if (brk_start) begin
            st     <= ST_BREAK;
            hi_cnt <= '0;
          end else if (frame_done) begin
            st      <= ST_IDLE;
            valid_q <= 1'b1;
            data_q  <= shreg;
            perr_q  <= parity_bad(^shreg, pbit, par_mode);
            ferr_q  <= !bit_val;
          end
        end
        ST_BREAK: begin
          if (brk_end) st <= ST_IDLE;
          else if (tick) hi_cnt <= rx ? hi_cnt + 1'b1 : '0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxb_status.sv
module rxb_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_a,
  input  logic set_b,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag <= 1'b0;
    else if (set_a || set_b) flag <= 1'b1;
    else if (clr)            flag <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_brk_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVS        = 16,
  parameter int END_TICKS  = 2,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        par_mode,
  input  logic              clr_status,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err,
  output logic              brk_flag
);
  logic rx_s;
  logic bit_mid_w, bit_val_w, bit_end_w;
  logic restart_w, active_w;
  logic frame_done_w, brk_start_w, brk_end_w, in_break_w;

  rxb_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
  );

  rxb_bit_timer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
    .restart(restart_w), .active(active_w),
    .bit_mid(bit_mid_w), .bit_val(bit_val_w), .bit_end(bit_end_w)
  );

  rxb_frame_fsm #(.DATA_W(DATA_W), .END_TICKS(END_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s), .par_mode(par_mode),
    .bit_mid(bit_mid_w), .bit_val(bit_val_w), .bit_end(bit_end_w),
    .restart(restart_w), .active(active_w),
    .data_q(rx_data), .valid_q(rx_valid), .perr_q(par_err), .ferr_q(frm_err),
    .frame_done(frame_done_w), .brk_start(brk_start_w), .brk_end(brk_end_w),
    .in_break(in_break_w)
  );

  rxb_status u_status (
    .clk(clk), .rst_n(rst_n), .set_a(brk_start_w), .set_b(brk_end_w),
    .clr(clr_status), .flag(brk_flag)
  );
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic clr_status,
  input logic rx_valid,
  input logic par_err,
  input logic frm_err,
  input logic brk_flag,
  input logic frame_done,
  input logic brk_start,
  input logic brk_end,
  input logic in_break
);
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_valid_follows_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_valid);

  assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(frm_err) && $stable(par_err)));

  assert_break_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |=> (brk_flag && !rx_valid));

  assert_events_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_done, brk_start, brk_end}));

  assert_end_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end |=> brk_flag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !clr_status) |=> brk_flag);

  assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !brk_start && !brk_end) |=> !brk_flag);

  assert_quiet_in_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |=> !rx_valid);
endmodule

bind uart_rx_brk uart_rx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_status(clr_status),
  .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err), .brk_flag(brk_flag),
  .frame_done(frame_done_w), .brk_start(brk_start_w), .brk_end(brk_end_w),
  .in_break(in_break_w)
);

// File: tb/tb_uart_rx_brk.sv
module tb_uart_rx_brk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] pm = 2'b00;
  logic       clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, frm_err, brk_flag;

  int n_chk = 0;
  int n_err = 0;
  int tdiv = 3;
  int tcnt = 0;
  bit done = 0;

  uart_rx_brk dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_mode(pm),
    .clr_status(clr), .rx_data(rx_data), .rx_valid(rx_valid),
    .par_err(par_err), .frm_err(frm_err), .brk_flag(brk_flag)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tcnt >= tdiv - 1) begin tcnt = 0; tick = 1'b1; end
    else begin tcnt++; tick = 1'b0; end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   ph = 0;            // 0 idle,1 start,2 data,3 parity,4 stop,5 break
  int   pos = 0;
  int   hi_run = 0;
  bit   m_s1 = 1, m_s2 = 1;
  bit   bits[$];
  bit   smp[$];
  bit   m_pbit = 0;
  bit   e_valid = 0, e_perr = 0, e_ferr = 0, e_brk = 0;
  logic [7:0] e_data = 8'h00;

  always @(posedge clk) begin
    bit cur, b, brk_hit, zero;
    int votes, ones;
    if (!rst_n) begin
      ph = 0; m_s1 = 1; m_s2 = 1; e_valid = 0; e_perr = 0; e_ferr = 0;
      e_brk = 0; e_data = 0; bits.delete(); smp.delete();
    end else begin
      cur = m_s2; m_s2 = m_s1; m_s1 = rxd;
      e_valid = 0;
      brk_hit = 0;
      if (tick) begin
        if (ph == 0) begin
          if (!cur) begin ph = 1; pos = 0; smp.delete(); bits.delete(); end
        end else if (ph == 5) begin
          if (cur) hi_run++; else hi_run = 0;
          if (hi_run >= 2) begin ph = 0; brk_hit = 1; end
        end else begin
          pos = (pos + 1) % 16;
          if (pos >= 7 && pos <= 9) smp.push_back(cur);
          if (pos == 9) begin
            votes = 0;
            foreach (smp[i]) votes += smp[i];
            b = (votes >= 2);
            smp.delete();
            if (ph == 1 && b) ph = 0;
            else if (ph == 2) bits.push_back(b);
            else if (ph == 3) m_pbit = b;
            else if (ph == 4) begin
              zero = !b;
              foreach (bits[i]) if (bits[i]) zero = 0;
              if ((pm == 2'b01 || pm == 2'b10) && m_pbit) zero = 0;
              if (zero) begin ph = 5; hi_run = 0; brk_hit = 1; end
              else begin
                ph = 0; e_valid = 1; e_ferr = !b;
                ones = 0;
                foreach (bits[i]) begin e_data[i] = bits[i]; ones += bits[i]; end
                if (pm == 2'b01)      e_perr = ((ones + m_pbit) % 2) != 0;
                else if (pm == 2'b10) e_perr = ((ones + m_pbit) % 2) == 0;
                else                  e_perr = 0;
              end
            end
          end
          if (pos == 0) begin
            if (ph == 1) ph = 2;
            else if (ph == 2 && bits.size() == 8) ph = (pm == 2'b01 || pm == 2'b10) ? 3 : 4;
            else if (ph == 3) ph = 4;
          end
        end
      end
      if (brk_hit) e_brk = 1;
      else if (clr) e_brk = 0;
    end
  end

  // per-cycle comparison and capture of delivered frames
  int nvalid = 0;
  logic [7:0] cap_data = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 rx_valid", rx_valid, e_valid);
      check("R2 rx_data", rx_data, e_data);
      check("R3 par_err", par_err, e_perr);
      check("R4 frm_err", frm_err, e_ferr);
      check("R8 brk_flag", brk_flag, e_brk);
      if (rx_valid) begin nvalid++; cap_data = rx_data; end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hold(input bit lvl, input int nt);
    int k;
    @(negedge clk);
    rxd = lvl;
    k = 0;
    while (k < nt) begin
      @(posedge clk);
      if (tick) k++;
    end
  endtask

  task automatic send(input logic [7:0] d, input bit has_par, input bit pb, input bit stop_lvl);
    hold(0, 16);
    for (int i = 0; i < 8; i++) hold(d[i], 16);
    if (has_par) hold(pb, 16);
    hold(stop_lvl, 16);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int v0;
    logic f0;
    repeat (5) @(negedge clk);
    check("R1 reset valid", rx_valid, 0);
    check("R1 reset data", rx_data, 0);
    check("R1 reset flags", {par_err, frm_err, brk_flag}, 0);
    rst_n = 1'b1;
    hold(1, 20);
    @(negedge clk);
    check("R1 idle after reset", {rx_valid, par_err, frm_err, brk_flag}, 0);

    // R2 plain frames
    v0 = nvalid;
    send(8'hA5, 0, 0, 1); hold(1, 16); @(negedge clk);
    check("R2 frame count", nvalid, v0 + 1);
    check("R2 data lsb first", cap_data, 8'hA5);
    send(8'h3E, 0, 0, 1); hold(1, 16); @(negedge clk);
    check("R2 second data", cap_data, 8'h3E);

    // R3 parity modes
    pm = 2'b01;
    send(8'h07, 1, 1, 1); hold(1, 16); @(negedge clk);
    check("R3 even ok", par_err, 0);
    send(8'h07, 1, 0, 1); hold(1, 16); @(negedge clk);
    check("R3 even bad", par_err, 1);
    pm = 2'b10;
    send(8'h81, 1, 1, 1); hold(1, 16); @(negedge clk);
    check("R3 odd ok", par_err, 0);
    send(8'h81, 1, 0, 1); hold(1, 16); @(negedge clk);
    check("R3 odd bad", par_err, 1);
    pm = 2'b11;
    send(8'h12, 0, 0, 1); hold(1, 16); @(negedge clk);
    check("R3 mode 11 none", par_err, 0);
    check("R3 mode 11 data", cap_data, 8'h12);

    // R4 framing error
    pm = 2'b00;
    send(8'h3C, 0, 0, 0); hold(1, 16); @(negedge clk);
    check("R4 frm_err set", frm_err, 1);
    check("R4 no break", brk_flag, 0);
    check("R4 data", cap_data, 8'h3C);

    // R5 break start
    v0 = nvalid; f0 = frm_err;
    send(8'h00, 0, 0, 0); hold(0, 40); @(negedge clk);
    check("R5 brk_flag set", brk_flag, 1);
    check("R5 no valid", nvalid, v0);
    check("R5 frm_err unchanged", frm_err, f0);

    // R8 clear while still low
    pulse_clr(); hold(0, 20); @(negedge clk);
    check("R8 cleared stays low", brk_flag, 0);

    // R9 single high tick does not end break
    hold(1, 1); hold(0, 30); @(negedge clk);
    check("R9 break not ended", brk_flag, 0);
    check("R9 no frame in break", nvalid, v0);

    // R7 end of break
    hold(1, 4); hold(1, 16); @(negedge clk);
    check("R7 end sets flag", brk_flag, 1);
    pulse_clr(); @(negedge clk);
    check("R8 clear pulse", brk_flag, 0);
    send(8'h55, 0, 0, 1); hold(1, 16); @(negedge clk);
    check("R7 receiver back", cap_data, 8'h55);

    // R6 parity bit high blocks break
    pm = 2'b01;
    send(8'h00, 1, 1, 0); hold(1, 16); @(negedge clk);
    check("R6 parity high framing", frm_err, 1);
    check("R6 parity high no break", brk_flag, 0);
    v0 = nvalid;
    send(8'h00, 1, 0, 0); hold(0, 10); @(negedge clk);
    check("R6 parity low break", brk_flag, 1);
    check("R6 break no valid", nvalid, v0);
    hold(1, 20); pulse_clr();
    pm = 2'b00;
    send(8'h00, 0, 0, 1); hold(1, 16); @(negedge clk);
    check("R6 zero data high stop", {frm_err, brk_flag}, 0);
    check("R6 zero data delivered", nvalid, v0 + 1);

    // R10 start glitch
    v0 = nvalid;
    hold(0, 5); hold(1, 30); @(negedge clk);
    check("R10 glitch ignored", nvalid, v0);
    send(8'h96, 0, 0, 1); hold(1, 16); @(negedge clk);
    check("R10 frame after glitch", cap_data, 8'h96);

    // tick on every cycle
    tdiv = 1; pm = 2'b01;
    hold(1, 20);
    send(8'hC3, 1, 0, 1); hold(1, 16); @(negedge clk);
    check("R2 dense tick data", cap_data, 8'hC3);
    check("R3 dense tick parity", par_err, 0);
    hold(1, 20);
    finish_run();
  end
endmodule